// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This block gathers status events from an audio codec's analog section and turns them into software-visible flags and one interrupt line. Five event sources arrive as single-cycle strobes: short-circuit detect, headphone ramp-up complete, headphone ramp-down complete, digital gain-up complete and digital gain-down complete. A sixth source is derived inside the block: the raw headphone-jack level is synchronized, and any change of the synchronized level raises a jack-change event. Each event sets a sticky flag, and software clears the flag by writing 1 to its bit. The synchronized jack level is also reported live, alongside the flags.

A mask register selects which flags may drive the interrupt output. The two top bits of the mask register select one of four output forms: a level active high, a level active low, a one-cycle pulse active high, or a one-cycle pulse active low. Flags are captured even while masked, so software can poll sources that do not interrupt.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset the flag readback is 0x00 (with the jack input low), the mask readback is 0x3F and the interrupt output is low.
- R2: A strobe on evt_i[k] sets flag bit k at the next clock edge, and the flag stays set after the strobe ends. The encoding is bit 0 gain-down done, bit 1 gain-up done, bit 2 ramp-down done, bit 3 ramp-up done, bit 4 short-circuit.
- R3: Flag readback bit 6 shows the jack level delayed by two clock edges through a synchronizer, and it cannot be cleared by a write.
- R4: Any change of the synchronized jack level, rising or falling, sets the sticky flag bit 5 one clock edge after bit 6 changes.
- R5: A write with wr_sel_i = 0 clears every flag bit 5:0 whose data bit is 1 and leaves the others unchanged; data bits 7:6 have no effect, and data 0x3F clears all six flags. Readback bit 7 is always 0.
- R6: When a set event and a clearing write hit the same flag bit in one cycle, the flag ends up set.
- R7: A write with wr_sel_i = 1 loads all 8 bits of the mask register, read back on mask_o. Mask bit k = 1 keeps flag k away from the interrupt, but flag k still sets.
- R8: Form 00 (mask bits 7:6): irq_o is high whenever any flag bit 5:0 is set with its mask bit 0.
- R9: Form 01: irq_o is the inverse of the form 00 level.
- R10: Form 10: irq_o is high for exactly the one cycle in which an unmasked flag goes from 0 to 1 (the cycle its flag first reads 1); an already-set flag, a masked flag, or unmasking a flag that is already set gives no pulse.
- R11: Form 11: irq_o is the inverse of the form 10 pulse.
- R12: A mask write leaves the flags unchanged, and a flag write leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jack_i | input | 1 | Raw headphone-jack level, asynchronous |
| evt_i | input | 5 | Single-cycle event strobes, encoding as in R2 |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 1 | Write target: 0 flag register, 1 mask register |
| wr_data_i | input | 8 | Write data |
| flag_o | output | 8 | Flag readback: 7 zero, 6 jack level, 5 jack change, 4:0 events |
| mask_o | output | 8 | Mask readback: 7:6 output form, 5:0 source masks |
| irq_o | output | 1 | Interrupt output in the selected form |

## Verification
The hardest conditions to reach are a clearing write and a set event landing on the same flag in the same cycle, and the pulse forms where a flag that is already set gets unmasked, which must stay quiet. The bench drives those collisions on purpose for every source and every form. A long pseudo-random phase then mixes strobes, flag and mask writes and jack toggles on each cycle, and compares every output against a cycle model after each clock edge.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int unsigned EVT_N = 5;
  localparam int unsigned SRC_N = EVT_N + 1;
  localparam int unsigned REG_W = 8;
  localparam logic [REG_W-1:0] MASK_RST = REG_W'((1 << SRC_N) - 1);

  typedef enum logic [1:0] {
    FORM_LVL_HI = 2'b00,
    FORM_LVL_LO = 2'b01,
    FORM_PLS_HI = 2'b10,
    FORM_PLS_LO = 2'b11
  } irq_form_e;
endpackage

// File: rtl/cirq_jack_sync.sv
module cirq_jack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic jack_i,
  output logic lvl_o,
  output logic chg_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], jack_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o = sync_q[STAGES-1];
  assign chg_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cirq_flag_reg.sv
module cirq_flag_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] flag_q, flag_d;

  // set beats clear on collision
  for (genvar k = 0; k < N; k++) begin : g_bit
    assign flag_d[k] = set_i[k] | (flag_q[k] & ~clr_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign rise_o = flag_d & ~flag_q;
endmodule

// File: rtl/cirq_irq_fmt.sv
module cirq_irq_fmt
  import codec_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] mask_wd_i,
  input  logic [SRC_N-1:0] flag_i,
  input  logic [SRC_N-1:0] rise_i,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic [REG_W-1:0] mask_q;
  logic             pulse_q;
  logic             lvl;
  irq_form_e        form;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= MASK_RST;
      pulse_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wd_i;
      // pulse judged against the mask in force when the flag rises
      pulse_q <= |(rise_i & ~mask_q[SRC_N-1:0]);
    end
  end

  assign lvl  = |(flag_i & ~mask_q[SRC_N-1:0]);
  assign form = irq_form_e'(mask_q[REG_W-1 -: 2]);

  always_comb begin
    unique case (form)
      FORM_LVL_HI: irq_o = lvl;
      FORM_LVL_LO: irq_o = ~lvl;
      FORM_PLS_HI: irq_o = pulse_q;
      FORM_PLS_LO: irq_o = ~pulse_q;
      default:     irq_o = lvl;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
  import codec_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             jack_i,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] flag_o,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  localparam int unsigned PAD_W = REG_W - SRC_N - 1;

  logic             jack_lvl, jack_chg;
  logic [SRC_N-1:0] set_v, clr_v, flags, rise;

  cirq_jack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .jack_i(jack_i),
    .lvl_o (jack_lvl),
    .chg_o (jack_chg)
  );

  assign set_v = {jack_chg, evt_i};
  assign clr_v = (wr_en_i && !wr_sel_i) ? wr_data_i[SRC_N-1:0] : '0;

  cirq_flag_reg #(.N(SRC_N)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .flag_o(flags),
    .rise_o(rise)
  );

  cirq_irq_fmt u_fmt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(wr_en_i && wr_sel_i),
    .mask_wd_i(wr_data_i),
    .flag_i   (flags),
    .rise_i   (rise),
    .mask_o   (mask_o),
    .irq_o    (irq_o)
  );

  assign flag_o = {{PAD_W{1'b0}}, jack_lvl, flags};
endmodule

// File: rtl/cirq_chk.sv
module cirq_chk
  import codec_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [EVT_N-1:0] evt_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] flag_o,
  input logic [REG_W-1:0] mask_o,
  input logic             irq_o
);
  for (genvar k = 0; k < EVT_N; k++) begin : g_src
    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flag_o[k]);
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[k] && !(wr_en_i && !wr_sel_i && wr_data_i[k])) |=> flag_o[k]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_sel_i && wr_data_i[k] && !evt_i[k]) |=> !flag_o[k]);
    p_collide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_sel_i && wr_data_i[k] && evt_i[k]) |=> flag_o[k]);
  end

  p_mask_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i) |=> $stable(mask_o));

  p_mask_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (mask_o == $past(wr_data_i)));

  p_quiet_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o[7:6] == 2'b00 && (flag_o[5:0] & ~mask_o[5:0]) == 6'h00) |-> !irq_o);

  p_quiet_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o[7:6] == 2'b01 && (flag_o[5:0] & ~mask_o[5:0]) == 6'h00) |-> irq_o);

  p_pulse_new_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o[7:6] == 2'b10 && irq_o) |-> (flag_o[5:0] != $past(flag_o[5:0])));
endmodule

bind codec_irq_unit cirq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .wr_data_i(wr_data_i),
  .flag_o   (flag_o),
  .mask_o   (mask_o),
  .irq_o    (irq_o)
);

// File: tb/tb_codec_irq_unit.sv
module tb_codec_irq_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       jack_i = 1'b0;
  logic [4:0] evt_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] flag_o, mask_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [5:0] m_flag;
  logic [7:0] m_mask;
  logic       m_j1, m_j2, m_jp, m_pulse;
  logic       jack_lvl = 1'b0;

  always #5 clk_i = ~clk_i;

  codec_irq_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .jack_i(jack_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .flag_o(flag_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    logic lvl;
    lvl = |(m_flag & ~m_mask[5:0]);
    case (m_mask[7:6])
      2'b00:   return lvl;
      2'b01:   return ~lvl;
      2'b10:   return m_pulse;
      default: return ~m_pulse;
    endcase
  endfunction

  task automatic step(input string tag, input logic [4:0] ev, input logic we,
                      input logic sel, input logic [7:0] d);
    logic       chg;
    logic [5:0] set_v, clr_v, f_new;
    evt_i = ev; wr_en_i = we; wr_sel_i = sel; wr_data_i = d; jack_i = jack_lvl;
    @(posedge clk_i);
    chg = m_j2 ^ m_jp;
    m_jp = m_j2; m_j2 = m_j1; m_j1 = jack_lvl;
    set_v = {chg, ev};
    clr_v = (we && !sel) ? d[5:0] : 6'h00;
    f_new = (m_flag & ~clr_v) | set_v;
    m_pulse = |(f_new & ~m_flag & ~m_mask[5:0]);
    m_flag = f_new;
    if (we && sel) m_mask = d;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0;
    check(tag, "flag", flag_o, {1'b0, m_j2, m_flag});
    check(tag, "mask", mask_o, m_mask);
    check(tag, "irq", {7'b0, irq_o}, {7'b0, exp_irq()});
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 5'h00, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    string tg;
    logic [15:0] lf;
    m_flag = '0; m_mask = 8'h3F; m_j1 = 0; m_j2 = 0; m_jp = 0; m_pulse = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1", "flag", flag_o, 8'h00);
    check("R1", "mask", mask_o, 8'h3F);
    check("R1", "irq", {7'b0, irq_o}, 8'h00);
    idle("R1", 2);

    // sweep forms x masked/unmasked x sources
    for (int f = 0; f < 4; f++) begin
      for (int mk = 0; mk < 2; mk++) begin
        for (int k = 0; k < 5; k++) begin
          case (f)
            0: tg = "R8";
            1: tg = "R9";
            2: tg = "R10";
            default: tg = "R11";
          endcase
          if (mk == 1) tg = "R7";
          step(tg, 5'h00, 1'b1, 1'b1,
               {f[1:0], (mk == 1) ? 6'h3F : (6'h3F & ~(6'h01 << k))});
          step("R2", 5'h01 << k, 1'b0, 1'b0, 8'h00);
          idle(tg, 2);
          step("R2", 5'h01 << k, 1'b0, 1'b0, 8'h00);     // already set
          step("R12", 5'h00, 1'b1, 1'b1, {f[1:0], 6'h00}); // unmask set flag
          idle(tg, 1);
          step("R6", 5'h01 << k, 1'b1, 1'b0, 8'h3F);      // collision
          step("R5", 5'h00, 1'b1, 1'b0, 8'hC0);           // 7:6 ignored
          step("R5", 5'h00, 1'b1, 1'b0, 8'h01 << k);
          idle(tg, 1);
        end
      end
    end

    // jack both directions in each form
    for (int f = 0; f < 4; f++) begin
      step("R7", 5'h00, 1'b1, 1'b1, {f[1:0], 6'h1F});
      jack_lvl = 1'b1;
      idle("R3", 4);
      step("R4", 5'h00, 1'b1, 1'b0, 8'h3F);
      jack_lvl = 1'b0;
      idle("R4", 4);
      step("R5", 5'h1F, 1'b0, 1'b0, 8'h00);
      step("R5", 5'h00, 1'b1, 1'b0, 8'h3F);
      idle("R12", 1);
    end

    // pseudo-random mix
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[11:9] == 3'b000) jack_lvl = ~jack_lvl;
      step("R2", lf[4:0] & lf[12:8], lf[7:5] == 3'b000, lf[14], lf[15:8]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule